// File: doc/BRIEF.md
# One-Wire ROM Search Controller

This block drives the master side of the search that enumerates devices sharing a one-wire line. It finds one 64-bit device identity on each pass. It does not drive the line itself. Instead it hands single operations to a bit-slot engine through a request/acknowledge handshake. The operations are a reset with presence detect, a write of 0, a write of 1, and a read.

A pass begins with a reset. If a device answers, the controller writes the 8-bit search command, least significant bit first. It then walks the 64 identity bits, least significant first. For each bit it performs two reads and then one write. The first read returns the true bit value that the remaining devices hold, wire-ANDed together. The second read returns the complement. The write selects the branch to follow, and every device whose bit differs from the written value drops out for the rest of the pass.

The controller keeps the path it took and the deepest position where it resolved a conflict by taking 0. Each later pass can therefore branch to 1 at that position and reach a device not yet found. A `done` pulse ends every pass. The `no_device` and `last_device` flags qualify the result and hold until the next accepted start.

Top module: `owire_search_ctrl`

## Requirements
- R1: An accepted `start` (while idle) issues a reset request, op code 0, as the first operation of the pass. When the read bit returned with that acknowledge is 0 (meaning no presence), the pass ends after that single operation, with `done` pulsed and `no_device` set.
- R2: After a presence bit of 1, the controller issues 8 write requests that carry the command byte (default 8'hF0), least significant bit first. Op code 1 writes 0 and op code 2 writes 1.
- R3: Each of the 64 identity bits uses two read requests (op code 3) followed by one write. A complete pass is therefore 1 reset, 72 writes and 128 reads.
- R4: Let the read pair be written {first, second}. A pair of 01 writes 0 and a pair of 10 writes 1. Identity bit i (bit 0 first) of `rom_id` equals the value written for that position.
- R5: A read pair of 11 ends the pass at once, with no write for that position. `done` pulses, `no_device` is set and `rom_id` reads 0.
- R6: On a pair of 00 (a conflict), the first pass writes 0. A later pass follows the previous path below the stored conflict position, writes 1 at that position, and writes 0 at any new conflict beyond it. Successive passes yield the devices in ascending order of their bit-reversed identities.
- R7: `last_device` is set at `done` when the pass took the 0 branch at no conflict. The next start then begins a new enumeration from the first device.
- R8: A start with `fresh` high discards the search history, so the pass returns the first device of the enumeration.
- R9: A `start` (with any `fresh` value) while a pass is busy has no effect on that pass.
- R10: Out of reset, and whenever the block is idle, `busy`, `slot_req` and `done` are low. `done` is a single-cycle pulse, after which `busy` is low.
- R11: `slot_req` stays high with a stable `slot_op` until `slot_ack` is seen. The read bit is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search pass when idle |
| fresh | input | 1 | With start: forget previous search history |
| slot_req | output | 1 | Operation request to the bit-slot engine |
| slot_op | output | 2 | Op code: 0 reset, 1 write 0, 2 write 1, 3 read |
| slot_ack | input | 1 | Single-cycle completion from the bit-slot engine |
| slot_rdbit | input | 1 | Read bit or presence bit, valid with slot_ack |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| no_device | output | 1 | Pass ended with no responding device |
| last_device | output | 1 | Pass found the final device of the enumeration |
| rom_id | output | ID_W | Identity found, bit 0 first on the wire |

## Verification
A wrong stored conflict position or a wrong stored path bit does not show on the pass where it is corrupted. It shows one pass later: the controller returns a repeated or skipped identity, or raises `last_device` too early. The bench therefore checks a full enumeration of four devices, plus a wrap-around pass after it. A wrong branch decision inside a pass shows within a single triplet, because the bus model then drops every device and answers 11, which turns into a `no_device` at the next done. The counts of operations per pass expose an extra or missing slot as soon as that pass ends.

// File: rtl/owire_search_ctrl.sv
module owire_search_ctrl #(
  parameter int ID_W = 64,
  parameter int CMD_W = 8,
  parameter logic [CMD_W-1:0] SEARCH_CMD = 8'hF0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            fresh,
  output logic            slot_req,
  output logic [1:0]      slot_op,
  input  logic            slot_ack,
  input  logic            slot_rdbit,
  output logic            busy,
  output logic            done,
  output logic            no_device,
  output logic            last_device,
  output logic [ID_W-1:0] rom_id
);

  localparam int BW = $clog2(ID_W);
  localparam int IW = BW + 1;
  localparam logic [1:0] OP_RST = 2'd0, OP_W0 = 2'd1, OP_W1 = 2'd2, OP_RD = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_CMD, S_RDA, S_RDB, S_WR} st_t;

  st_t              state;
  logic [CMD_W-1:0] cmd_sr;
  logic [$clog2(CMD_W)-1:0] cmd_cnt;
  logic [BW-1:0]    idx;
  logic [IW-1:0]    last_zero, pass_zero;
  logic [ID_W-1:0]  id_q;
  logic             bit_a, req_q, done_q, nodev_q, lastdev_q;
  logic [1:0]       op_q;

  logic [IW-1:0] idx1;
  logic          conf_dir, pick;
  logic [1:0]    pair;

  assign idx1     = IW'(idx) + IW'(1);
  assign conf_dir = (idx1 < last_zero) ? id_q[idx] : (idx1 == last_zero);
  assign pair     = {bit_a, slot_rdbit};
  assign pick     = (pair == 2'b10) ? 1'b1 : (pair == 2'b01) ? 1'b0 : conf_dir;

  assign slot_req    = req_q;
  assign slot_op     = op_q;
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign no_device   = nodev_q;
  assign last_device = lastdev_q;
  assign rom_id      = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_sr    <= '0;
      cmd_cnt   <= '0;
      idx       <= '0;
      last_zero <= '0;
      pass_zero <= '0;
      id_q      <= '0;
      bit_a     <= 1'b0;
      req_q     <= 1'b0;
      op_q      <= OP_RST;
      done_q    <= 1'b0;
      nodev_q   <= 1'b0;
      lastdev_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state     <= S_RST;
          req_q     <= 1'b1;
          op_q      <= OP_RST;
          nodev_q   <= 1'b0;
          lastdev_q <= 1'b0;
          pass_zero <= '0;
          idx       <= '0;
          if (fresh) last_zero <= '0;
        end
        S_RST: if (slot_ack) begin
          if (!slot_rdbit) begin
            state     <= S_IDLE;
            req_q     <= 1'b0;
            done_q    <= 1'b1;
            nodev_q   <= 1'b1;
            last_zero <= '0;
            id_q      <= '0;
          end else begin
            state   <= S_CMD;
            op_q    <= SEARCH_CMD[0] ? OP_W1 : OP_W0;
            cmd_sr  <= SEARCH_CMD >> 1;
            cmd_cnt <= '0;
          end
        end
        S_CMD: if (slot_ack) begin
          if (cmd_cnt == ($clog2(CMD_W))'(CMD_W - 1)) begin
            state <= S_RDA;
            op_q  <= OP_RD;
          end else begin
            cmd_cnt <= cmd_cnt + 1'b1;
            op_q    <= cmd_sr[0] ? OP_W1 : OP_W0;
            cmd_sr  <= cmd_sr >> 1;
          end
        end
        S_RDA: if (slot_ack) begin
          bit_a <= slot_rdbit;
          state <= S_RDB;
        end
        S_RDB: if (slot_ack) begin
          if (pair == 2'b11) begin
            state     <= S_IDLE;
            req_q     <= 1'b0;
            done_q    <= 1'b1;
            nodev_q   <= 1'b1;
            last_zero <= '0;
            id_q      <= '0;
          end else begin
            id_q[idx] <= pick;
            if (pair == 2'b00 && !pick) pass_zero <= idx1;
            op_q  <= pick ? OP_W1 : OP_W0;
            state <= S_WR;
          end
        end
        S_WR: if (slot_ack) begin
          if (idx == BW'(ID_W - 1)) begin
            state     <= S_IDLE;
            req_q     <= 1'b0;
            done_q    <= 1'b1;
            last_zero <= pass_zero;
            lastdev_q <= (pass_zero == '0);
          end else begin
            idx   <= idx + 1'b1;
            op_q  <= OP_RD;
            state <= S_RDA;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_ack) |=> (slot_req && $stable(slot_op))); // R11
  AST_START_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (slot_req && slot_op == OP_RST)); // R1
  AST_WRITE_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RDB && slot_ack && !(bit_a && slot_rdbit)) |=> (slot_op == OP_W0 || slot_op == OP_W1)); // R3
  AST_NODEV_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_device) |-> done); // R5
  AST_LASTDEV_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_device) |-> done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !slot_req); // R10

endmodule

// File: tb/sim_owire_search_ctrl.sv
module sim_owire_search_ctrl;
  logic clk = 0, rst_n = 0, start = 0, fresh = 0, slot_ack = 0, slot_rdbit = 0;
  logic slot_req, busy, done, no_device, last_device;
  logic [1:0] slot_op;
  logic [63:0] rom_id;

  always #5 clk = ~clk;

  owire_search_ctrl u0 (.clk(clk), .rst_n(rst_n), .start(start), .fresh(fresh),
    .slot_req(slot_req), .slot_op(slot_op), .slot_ack(slot_ack), .slot_rdbit(slot_rdbit),
    .busy(busy), .done(done), .no_device(no_device), .last_device(last_device), .rom_id(rom_id));

  int checks = 0, failures = 0;
  logic [63:0] dev_id [4];
  bit dev_on [4], dev_act [4];
  int n_tr, n_rst, n_wr, n_rd, nwr, rbit, rd_n, vanish_at = -1, op_glitch = 0;
  logic [7:0] cmd_seen;

  initial begin : engine
    logic [1:0] op;
    logic res;
    forever begin
      @(negedge clk);
      if (slot_req) begin
        op = slot_op;
        n_tr++;
        repeat (2) @(negedge clk);
        if (slot_op !== op) op_glitch++;
        res = 1'b1;
        case (op)
          2'd0: begin
            n_rst++; res = 1'b0; nwr = 0; rbit = 0; rd_n = 0; cmd_seen = 0;
            for (int k = 0; k < 4; k++) begin dev_act[k] = dev_on[k]; res = res | dev_on[k]; end
          end
          2'd1, 2'd2: begin
            n_wr++;
            if (nwr < 8) begin cmd_seen[nwr] = (op == 2'd2); nwr++; end
            else begin
              for (int k = 0; k < 4; k++)
                if (dev_act[k] && dev_id[k][rbit] != (op == 2'd2)) dev_act[k] = 0;
              rbit++; rd_n = 0;
            end
          end
          default: begin
            n_rd++;
            if (rbit == vanish_at) for (int k = 0; k < 4; k++) dev_act[k] = 0;
            for (int k = 0; k < 4; k++)
              if (dev_act[k]) res = res & (rd_n == 1 ? ~dev_id[k][rbit] : dev_id[k][rbit]);
            rd_n++;
          end
        endcase
        slot_rdbit = res;
        slot_ack = 1;
        @(negedge clk);
        slot_ack = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rev(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63 - i];
    return r;
  endfunction

  task automatic run_pass(input bit fr, input bit poke);
    int lim = 0;
    n_tr = 0; n_rst = 0; n_wr = 0; n_rd = 0;
    @(negedge clk); start = 1; fresh = fr;
    @(negedge clk); start = 0; fresh = 0;
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1; fresh = 1;
      @(negedge clk); start = 0; fresh = 0;
    end
    while (!done && lim < 5000) begin @(negedge clk); lim++; end
    if (!done) chk("R10 pass timeout", 0, 1);
  endtask

  task automatic t_reset;
    chk("R10 busy after reset", busy, 0);
    chk("R10 req after reset", slot_req, 0);
    chk("R10 done after reset", done, 0);
    chk("R10 flags after reset", {no_device, last_device}, 0);
    chk("R10 id after reset", rom_id, 0);
  endtask

  task automatic t_empty;
    for (int k = 0; k < 4; k++) dev_on[k] = 0;
    run_pass(0, 0);
    chk("R1 no_device on no presence", no_device, 1);
    chk("R1 single op in empty pass", n_tr, 1);
    chk("R1 op was reset", n_rst, 1);
  endtask

  task automatic t_single;
    dev_id[0] = 64'h8D00_0000_0012_3401; dev_on[0] = 1;
    run_pass(0, 0);
    chk("R4 id of single device", rom_id, dev_id[0]);
    chk("R2 command byte", cmd_seen, 8'hF0);
    chk("R3 read count", n_rd, 128);
    chk("R3 write count", n_wr, 72);
    chk("R3 reset count", n_rst, 1);
    chk("R7 last_device single", last_device, 1);
    chk("R5 no_device clear", no_device, 0);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 busy low after done", busy, 0);
    chk("R11 op stable until ack", op_glitch, 0);
  endtask

  task automatic t_vanish;
    vanish_at = 20;
    run_pass(0, 0);
    chk("R5 no_device on 11", no_device, 1);
    chk("R5 id cleared", rom_id, 0);
    chk("R5 no write after 11", n_wr, 8 + 20);
    vanish_at = -1;
    run_pass(0, 0);
    chk("R5 recovery pass id", rom_id, dev_id[0]);
  endtask

  task automatic t_multi;
    logic [63:0] ord [4];
    logic [63:0] t;
    dev_id[0] = 64'h1C00_0000_0000_0A28; dev_id[1] = 64'h8D00_0000_0012_3401;
    dev_id[2] = 64'h2200_00AB_CDEF_0010; dev_id[3] = 64'h5A00_0000_0000_0A29;
    for (int k = 0; k < 4; k++) begin dev_on[k] = 1; ord[k] = dev_id[k]; end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (rev(ord[j]) > rev(ord[j + 1])) begin t = ord[j]; ord[j] = ord[j + 1]; ord[j + 1] = t; end
    run_pass(1, 0);
    chk("R6 pass 1 id", rom_id, ord[0]);
    chk("R7 pass 1 not last", last_device, 0);
    run_pass(0, 1);
    chk("R9 start during pass ignored id", rom_id, ord[1]);
    chk("R9 start during pass op count", n_tr, 201);
    run_pass(0, 0);
    chk("R6 pass 3 id", rom_id, ord[2]);
    chk("R7 pass 3 not last", last_device, 0);
    run_pass(0, 0);
    chk("R6 pass 4 id", rom_id, ord[3]);
    chk("R7 pass 4 last", last_device, 1);
    run_pass(0, 0);
    chk("R7 wrap to first", rom_id, ord[0]);
    run_pass(0, 0);
    chk("R8 history kept without fresh", rom_id, ord[1]);
    run_pass(1, 0);
    chk("R8 fresh restarts", rom_id, ord[0]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk("R10 watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_empty;
    t_single;
    t_vanish;
    t_multi;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule